// File: doc/BRIEF.md
# Dual Interrupt Output Controller

This block is the command-register logic that sits between two alarm sources and two interrupt pins. The two sources are a countdown watchdog and a time-of-day comparator. Each source sends a one-cycle event strobe. The block latches that strobe as a readable flag and decides whether it reaches a pin. Each source has its own mask bit. A single switch bit chooses which source drives pin A and which drives pin B.

Two signalling modes exist:

- **Level mode:** an interrupt stays asserted until software touches that source's alarm registers. The alarm blocks report that touch as an access strobe.
- **Pulse mode:** an interrupt is stretched over a fixed number of millisecond ticks and then drops by itself. The readable flag follows the pulse.

The command byte also holds two bits that are passed straight out to neighbouring logic:

- a transfer-enable bit, which lets the clock registers update;
- a drive-sense bit, which tells the pad logic whether pin B sources or sinks current.

Top module: `irq_dual_ctrl`

## Requirements
- R1: After synchronous reset the command byte reads 0xCC and both interrupt outputs are low. The reset state is: transfer enable 1, switch 1, drive sense 0, level mode, both masks 1, both flags 0.
- R2: A write stores bits 7..2 of the command byte. The stored byte reads back on the next cycle. Written values of bits 1 and 0 are ignored, so the flags read the same after the write as before it.
- R3: In level mode (bit 4 = 0), an event strobe makes its flag read 1 on the cycle after the strobe. The flag stays 1 until an access strobe for the same source. The watchdog flag is bit 1 and the time-of-day flag is bit 0.
- R4: An access strobe clears its source's flag and pulse on the next cycle. This holds even when an event strobe for that source arrives in the same cycle.
- R5: In pulse mode (bit 4 = 1), an event starts a pulse that lasts until the ms tick that is the fourth after the event. The fourth tick is PULSE_TICKS + 1 with the default PULSE_TICKS of 3. The flag reads 1 exactly while the pulse lasts.
- R6: A new event during a pulse restarts the full pulse length.
- R7: The watchdog mask (bit 3) and the time-of-day mask (bit 2) each keep their source off both pins when set to 1. The flags still set when a source is masked.
- R8: With the switch (bit 6) at 1, pin A carries the time-of-day interrupt and pin B carries the watchdog. With the switch at 0 the two are exchanged.
- R9: Bit 5 appears on `irq_b_source` and bit 7 appears on `xfer_en`, both directly from the stored byte.
- R10: In pulse mode, an access strobe ends a running pulse on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command byte |
| cmd_wdata | input | 8 | Command byte write data |
| cmd_rdata | output | 8 | Command byte read value, flags included |
| wd_evt | input | 1 | Watchdog alarm event strobe |
| tod_evt | input | 1 | Time-of-day alarm event strobe |
| wd_acc | input | 1 | Watchdog alarm register access strobe |
| tod_acc | input | 1 | Time-of-day alarm register access strobe |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| irq_a | output | 1 | Interrupt pin A, active high |
| irq_b | output | 1 | Interrupt pin B, active high |
| irq_b_source | output | 1 | Drive sense for pin B: 1 sources current, 0 sinks |
| xfer_en | output | 1 | Clock register transfer enable |

## Verification
Every result is one register stage behind its cause. Flags, pins and the readback of a write all change at the first clock edge after the strobe. Pin levels follow the flags combinationally, with no further delay.

The bench drives every stimulus on a falling edge and removes it on the next falling edge. The rising edge in between is the only one that captures it, so each check sampled after that is aligned to the one-cycle latency. Pulse checks go one tick at a time and sample after each tick. This pins the drop to the fourth tick exactly and rules out the third or fifth.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Source indices into per-source vectors
    typedef enum logic {
        SRC_WD  = 1'b0,
        SRC_TOD = 1'b1
    } src_e;

    localparam int NUM_SRC = 2;

    // Stored part of the command byte, MSB first = byte bit 7
    typedef struct packed {
        logic xfer_en;   // bit 7
        logic swap;      // bit 6
        logic b_source;  // bit 5
        logic pulse;     // bit 4
        logic wd_mask;   // bit 3
        logic tod_mask;  // bit 2
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        xfer_en:  1'b1,
        swap:     1'b1,
        b_source: 1'b0,
        pulse:    1'b0,
        wd_mask:  1'b1,
        tod_mask: 1'b1
    };

    function automatic ctl_t ctl_from_byte(input logic [7:0] b);
        return ctl_t'(b[7:2]);
    endfunction

    function automatic logic [7:0] byte_from_ctl(input ctl_t c,
                                                 input logic wd_flag,
                                                 input logic tod_flag);
        return {c, wd_flag, tod_flag};
    endfunction

    function automatic logic src_mask(input ctl_t c, input int idx);
        return (idx == int'(SRC_WD)) ? c.wd_mask : c.tod_mask;
    endfunction

endpackage

// File: rtl/intc_cmd_reg.sv
module intc_cmd_reg
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output ctl_t       ctl_o
);

    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
        end else if (wr_i) begin
            ctl_q <= ctl_from_byte(wdata_i);
        end
    end

    assign ctl_o = ctl_q;

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(ctl_q)); // R2

    AST_CTL_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (ctl_q == ctl_from_byte($past(wdata_i)))); // R2

endmodule

// File: rtl/intc_src_chan.sv
module intc_src_chan #(
    parameter int PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic event_i,
    input  logic access_i,
    input  logic tick_i,
    input  logic pulse_mode_i,
    output logic flag_o
);

    // One extra tick so a partial first period never shortens the pulse
    localparam int LOAD  = PULSE_TICKS + 1;
    localparam int CNT_W = $clog2(LOAD + 1);

    logic             held_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            cnt_q  <= '0;
        end else if (access_i) begin
            held_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (event_i) begin
                held_q <= 1'b1;
            end
            if (event_i) begin
                cnt_q <= CNT_W'(LOAD);
            end else if (tick_i && (cnt_q != '0)) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign flag_o = pulse_mode_i ? (cnt_q != '0) : held_q;

    AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        access_i |=> (!held_q && (cnt_q == '0))); // R4

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        (event_i && !access_i) |=> held_q); // R3

    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (event_i && !access_i) |=> (cnt_q == CNT_W'(LOAD))); // R6

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(LOAD)); // R5

    AST_HELD_STICKY: assert property (@(posedge clk) disable iff (rst)
        (held_q && !access_i) |=> held_q); // R3

endmodule

// File: rtl/intc_router.sv
module intc_router
    import intc_pkg::*;
(
    input  ctl_t               ctl_i,
    input  logic [NUM_SRC-1:0] flag_i,
    output logic               irq_a_o,
    output logic               irq_b_o
);

    logic [NUM_SRC-1:0] live;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_gate
        assign live[s] = flag_i[s] & ~src_mask(ctl_i, s);
    end

    always_comb begin
        if (ctl_i.swap) begin
            irq_a_o = live[SRC_TOD];
            irq_b_o = live[SRC_WD];
        end else begin
            irq_a_o = live[SRC_WD];
            irq_b_o = live[SRC_TOD];
        end
    end

    always_comb begin
        if (ctl_i.wd_mask && ctl_i.tod_mask) begin
            AST_ALL_MASKED: assert (!irq_a_o && !irq_b_o); // R7
        end
        if (flag_i == '0) begin
            AST_NO_FLAG_NO_IRQ: assert (!irq_a_o && !irq_b_o); // R7
        end
    end

endmodule

// File: rtl/irq_dual_ctrl.sv
module irq_dual_ctrl
    import intc_pkg::*;
#(
    parameter int PULSE_TICKS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_wdata,
    output logic [7:0] cmd_rdata,
    input  logic       wd_evt,
    input  logic       tod_evt,
    input  logic       wd_acc,
    input  logic       tod_acc,
    input  logic       ms_tick,
    output logic       irq_a,
    output logic       irq_b,
    output logic       irq_b_source,
    output logic       xfer_en
);

    ctl_t               ctl;
    logic [NUM_SRC-1:0] evt_v;
    logic [NUM_SRC-1:0] acc_v;
    logic [NUM_SRC-1:0] flag_v;

    assign evt_v[SRC_WD]  = wd_evt;
    assign evt_v[SRC_TOD] = tod_evt;
    assign acc_v[SRC_WD]  = wd_acc;
    assign acc_v[SRC_TOD] = tod_acc;

    intc_cmd_reg u_cmd (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (cmd_wr),
        .wdata_i (cmd_wdata),
        .ctl_o   (ctl)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_chan
        intc_src_chan #(.PULSE_TICKS(PULSE_TICKS)) u_chan (
            .clk          (clk),
            .rst          (rst),
            .event_i      (evt_v[s]),
            .access_i     (acc_v[s]),
            .tick_i       (ms_tick),
            .pulse_mode_i (ctl.pulse),
            .flag_o       (flag_v[s])
        );
    end

    intc_router u_route (
        .ctl_i   (ctl),
        .flag_i  (flag_v),
        .irq_a_o (irq_a),
        .irq_b_o (irq_b)
    );

    assign cmd_rdata    = byte_from_ctl(ctl, flag_v[SRC_WD], flag_v[SRC_TOD]);
    assign irq_b_source = ctl.b_source;
    assign xfer_en      = ctl.xfer_en;

    AST_WD_ACC_DROPS: assert property (@(posedge clk) disable iff (rst)
        wd_acc |=> !cmd_rdata[1]); // R10

    AST_TOD_ACC_DROPS: assert property (@(posedge clk) disable iff (rst)
        tod_acc |=> !cmd_rdata[0]); // R10

    AST_PINS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $countones({irq_a, irq_b}) <= $countones(flag_v)); // R8

endmodule

// File: tb/irq_dual_ctrl_bench.sv
`timescale 1ns/1ps
module irq_dual_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_wdata = 8'h00;
    logic [7:0] cmd_rdata;
    logic       wd_evt = 1'b0, tod_evt = 1'b0, wd_acc = 1'b0, tod_acc = 1'b0;
    logic       ms_tick = 1'b0;
    logic       irq_a, irq_b, irq_b_source, xfer_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_dual_ctrl u_irq_dual_ctrl (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .wd_evt(wd_evt), .tod_evt(tod_evt),
        .wd_acc(wd_acc), .tod_acc(tod_acc), .ms_tick(ms_tick),
        .irq_a(irq_a), .irq_b(irq_b), .irq_b_source(irq_b_source),
        .xfer_en(xfer_en)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic write_cmd(input logic [7:0] v);
        cmd_wr = 1'b1; cmd_wdata = v;
        cyc();
        cmd_wr = 1'b0;
    endtask

    task automatic strobe(input logic w_e, input logic t_e, input logic w_a, input logic t_a);
        wd_evt = w_e; tod_evt = t_e; wd_acc = w_a; tod_acc = t_a;
        cyc();
        wd_evt = 1'b0; tod_evt = 1'b0; wd_acc = 1'b0; tod_acc = 1'b0;
    endtask

    task automatic tick();
        ms_tick = 1'b1;
        cyc();
        ms_tick = 1'b0;
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        chk("R1 rdata", cmd_rdata, 8'hCC);
        chk("R1 irq", {6'd0, irq_a, irq_b}, 8'h00);

        // R2 store bits 7..2, ignore 1..0
        write_cmd(8'hFF);
        chk("R2 write FF", cmd_rdata, 8'hFC);
        write_cmd(8'h03);
        chk("R2 write 03", cmd_rdata, 8'h00);

        // R9 passthrough bits
        write_cmd(8'h20);
        chk("R9 b_source/xfer", {6'd0, irq_b_source, xfer_en}, 8'h02);
        write_cmd(8'h80);
        chk("R9 b_source/xfer", {6'd0, irq_b_source, xfer_en}, 8'h01);

        // R3 R7 R8 level-mode sweep
        for (int c = 0; c < 8; c++) begin
            for (int p = 1; p < 4; p++) begin
                logic sw, wm, tm, we, te, wa, ta, ea, eb;
                sw = c[2]; wm = c[1]; tm = c[0];
                we = p[1]; te = p[0];
                write_cmd({1'b1, sw, 2'b00, wm, tm, 2'b00});
                strobe(we, te, 1'b0, 1'b0);
                wa = we & ~wm; ta = te & ~tm;
                ea = sw ? ta : wa; eb = sw ? wa : ta;
                chk("R3 flags set", {6'd0, cmd_rdata[1:0]}, {6'd0, we, te});
                chk("R7 R8 pins", {6'd0, irq_a, irq_b}, {6'd0, ea, eb});
                repeat (5) cyc();
                chk("R3 flags held", {6'd0, cmd_rdata[1:0]}, {6'd0, we, te});
                chk("R8 pins held", {6'd0, irq_a, irq_b}, {6'd0, ea, eb});
                strobe(1'b0, 1'b0, 1'b1, 1'b1);
                chk("R3 cleared", {5'd0, cmd_rdata[1:0], irq_a | irq_b}, 8'h00);
            end
        end

        // R3 per-source clearing: access to one source leaves the other
        write_cmd(8'hC0);
        strobe(1'b1, 1'b1, 1'b0, 1'b0);
        strobe(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R3 only wd cleared", {6'd0, cmd_rdata[1:0]}, 8'h01);
        strobe(1'b0, 1'b0, 1'b0, 1'b1);

        // R4 access wins over same-cycle event
        strobe(1'b1, 1'b1, 1'b1, 1'b1);
        chk("R4 access wins", {6'd0, cmd_rdata[1:0]}, 8'h00);

        // R2 flag bits not writable
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
        write_cmd(8'h80);
        chk("R2 flag kept on write 0", cmd_rdata, 8'h82);
        write_cmd(8'h81);
        chk("R2 flag not set by write", cmd_rdata, 8'h82);
        strobe(1'b0, 1'b0, 1'b1, 1'b0);

        // R5 pulse length: wd on pin A (switch 0), unmasked
        write_cmd(8'h90);
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 pulse start", {6'd0, irq_a, cmd_rdata[1]}, 8'h03);
        for (int k = 1; k <= 3; k++) begin
            tick();
            chk("R5 pulse holding", {6'd0, irq_a, cmd_rdata[1]}, 8'h03);
        end
        tick();
        chk("R5 pulse ended", {6'd0, irq_a, cmd_rdata[1]}, 8'h00);
        repeat (4) cyc();
        chk("R5 stays low", {6'd0, irq_a, cmd_rdata[1]}, 8'h00);

        // R6 retrigger: tod on pin B
        strobe(1'b0, 1'b1, 1'b0, 1'b0);
        tick(); tick();
        strobe(1'b0, 1'b1, 1'b0, 1'b0);
        for (int k = 1; k <= 3; k++) begin
            tick();
            chk("R6 retriggered holding", {6'd0, irq_b, cmd_rdata[0]}, 8'h03);
        end
        tick();
        chk("R6 retriggered end", {6'd0, irq_b, cmd_rdata[0]}, 8'h00);

        // R10 access ends pulse
        strobe(1'b1, 1'b1, 1'b0, 1'b0);
        tick();
        strobe(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10 wd pulse cut", {5'd0, irq_a, cmd_rdata[1:0]}, 8'h01);
        strobe(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 tod pulse cut", {6'd0, irq_b, cmd_rdata[0]}, 8'h00);

        // R7 mask in pulse mode: flag still pulses, pin stays low
        write_cmd(8'h98);
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7 masked pulse", {6'd0, irq_a, cmd_rdata[1]}, 8'h01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule